// File: doc/BRIEF.md
# Memory Word Protection with Fault Planting

This block guards 64-bit memory words with an 8-bit single-error-correct, double-error-detect check byte. It also has a test path that plants known faults. On every write the check byte is derived from the clean data. The stored data is then XORed with a 64-bit data flip mask, and the stored check byte is XORed with an 8-bit check flip mask. A single set bit across both masks therefore plants a fault the decoder can repair. Two set bits plant a fault it can only report.

A small behavioural store sits inside the block and holds the protected words. On a read, the block recomputes the syndrome over the stored word. It repairs a single flipped bit and raises a correctable flag, or it raises an uncorrectable flag. Results appear one cycle after the read request. A plain register write port loads the two masks. The masks stay in force until they are written again.

Top module: `ecc_inject_store`

## Requirements
- R1: After reset both flip masks are zero, so a word written and read back returns unchanged with both flags low; after reset `rd_valid`, `err_corr`, `err_uncorr` and `rd_data` are all zero.
- R2: With both masks zero, any written word reads back bit-exact with both flags low.
- R3: A single bit set in the data mask makes the next read of a word written under it raise `err_corr`, leave `err_uncorr` low, and return the original data with the flipped bit repaired.
- R4: A single bit set in the check mask makes the read raise `err_corr` with `err_uncorr` low and return the original data unchanged.
- R5: Two set bits across the masks (both in data, both in check, or one in each) make the read raise `err_uncorr` with `err_corr` low and return the stored raw data, equal to the written data XOR the data mask; the two flags are never high together.
- R6: A mask value applies only to writes made while it is loaded: words written earlier read back clean, and writing the mask back to zero restores clean writes.
- R7: A config write with `cfg_sel`=0 loads all 64 bits of `cfg_wdata` into the data mask; with `cfg_sel`=1 it loads `cfg_wdata[7:0]` into the check mask; the mask not selected keeps its value.
- R8: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high; both flags are low whenever `rd_valid` is low, and `rd_data` holds its value in such cycles.
- R9: A read and a write to the same address in the same cycle return the word stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the selected flip mask |
| cfg_sel | input | 1 | 0 selects data mask, 1 selects check mask |
| cfg_wdata | input | 64 | Mask value to load |
| wr_en | input | 1 | Write request |
| wr_addr | input | 4 | Write address |
| wr_data | input | 64 | Clean data to protect and store |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Read address |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Repaired data, or raw data if uncorrectable |
| err_corr | output | 1 | Single-bit error found and repaired |
| err_uncorr | output | 1 | Error that cannot be repaired |

## Verification
A wrong column in the parity matrix or a mis-applied mask shows at the ports in the very read that follows the faulty write. The symptom is a flag on a clean word, a missing flag on a planted fault, or a repair of the wrong bit. Every decode path is therefore exercised through planted faults at both ends of the data word and in both ends of the check byte. Mask-select errors show as the wrong class of fault on the next read. Errors in mask lifetime show when an older word is read back after the mask changes. Latency faults show at once as `rd_valid` or the flags in the wrong cycle.

// File: rtl/ecc_inject_store.sv
module ecc_inject_store #(
  parameter int DW    = 64,
  parameter int CW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          err_corr,
  output logic          err_uncorr
);

  localparam int WW = DW + CW;

  function automatic int weight(input int v);
    int n;
    n = 0;
    for (int b = 0; b < CW; b++) n += (v >> b) & 1;
    return n;
  endfunction

  function automatic logic [DW-1:0][CW-1:0] build_cols();
    logic [DW-1:0][CW-1:0] h;
    int n;
    h = '0;
    n = 0;
    for (int w = 3; w <= CW; w += 2)
      for (int v = 0; v < (1 << CW); v++)
        if (weight(v) == w && n < DW) begin
          h[n] = v[CW-1:0];
          n++;
        end
    return h;
  endfunction

  localparam logic [DW-1:0][CW-1:0] HCOL = build_cols();

  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < DW; i++)
      if (d[i]) c ^= HCOL[i];
    return c;
  endfunction

  logic [DW-1:0] dmask;
  logic [CW-1:0] cmask;
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dmask <= '0;
      cmask <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) cmask <= cfg_wdata[CW-1:0];
      else         dmask <= cfg_wdata;
    end
  end

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= {encode(wr_data) ^ cmask, wr_data ^ dmask};

  logic [WW-1:0] raw;
  logic [DW-1:0] sdat, fixed;
  logic [CW-1:0] syn;
  logic          hit, corr_n, unc_n;

  assign raw  = mem[rd_addr];
  assign sdat = raw[DW-1:0];
  assign syn  = encode(sdat) ^ raw[DW +: CW];

  always_comb begin
    fixed  = sdat;
    hit    = 1'b0;
    corr_n = 1'b0;
    unc_n  = 1'b0;
    if (syn != '0) begin
      if (^syn) begin
        for (int i = 0; i < DW; i++)
          if (syn == HCOL[i]) begin
            fixed[i] = ~sdat[i];
            hit      = 1'b1;
          end
        for (int j = 0; j < CW; j++)
          if (syn == (CW'(1) << j)) hit = 1'b1;
        corr_n = hit;
        unc_n  = ~hit;
      end else begin
        unc_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      err_corr   <= 1'b0;
      err_uncorr <= 1'b0;
    end else begin
      rd_valid   <= rd_en;
      err_corr   <= rd_en & corr_n;
      err_uncorr <= rd_en & unc_n;
      if (rd_en) rd_data <= fixed;
    end
  end

endmodule

module ecc_inject_store_chk #(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          cfg_sel,
  input logic [DW-1:0] cfg_wdata,
  input logic          rd_en,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          err_corr,
  input logic          err_uncorr,
  input logic [DW-1:0] dmask,
  input logic [CW-1:0] cmask
);

  // R8
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R8
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (!err_corr && !err_uncorr));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_corr && err_uncorr));

  // R7
  dmask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> (dmask == $past(cfg_wdata) && $stable(cmask)));

  // R7
  cmask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> (cmask == $past(cfg_wdata[CW-1:0]) && $stable(dmask)));

endmodule

bind ecc_inject_store ecc_inject_store_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_data(rd_data), .err_corr(err_corr), .err_uncorr(err_uncorr),
  .dmask(dmask), .cmask(cmask)
);

// File: tb/sim_ecc_inject_store.sv
module sim_ecc_inject_store;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic        rd_valid, err_corr, err_uncorr;
  logic [63:0] rd_data;

  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ecc_inject_store u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_corr(err_corr), .err_uncorr(err_uncorr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mask(input logic sel, input logic [63:0] v);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d,
                    output logic c, output logic u, output logic v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    d = rd_data; c = err_corr; u = err_uncorr; v = rd_valid;
    rd_en = 1'b0;
  endtask

  task automatic expect_read(input string req, input logic [3:0] a, input logic [63:0] ed,
                             input logic ec, input logic eu);
    logic [63:0] d; logic c, u, v;
    rd(a, d, c, u, v);
    check({req, " valid"}, 64'(v), 64'(1));
    check({req, " data"}, d, ed);
    check({req, " corr"}, 64'(c), 64'(ec));
    check({req, " uncorr"}, 64'(u), 64'(eu));
  endtask

  task automatic t_reset();
    check("R1 rd_valid", 64'(rd_valid), 0);
    check("R1 err_corr", 64'(err_corr), 0);
    check("R1 err_uncorr", 64'(err_uncorr), 0);
    check("R1 rd_data", rd_data, 0);
    wr(4'd0, 64'h0123_4567_89AB_CDEF);
    expect_read("R1", 4'd0, 64'h0123_4567_89AB_CDEF, 0, 0);
  endtask

  task automatic t_clean();
    logic [63:0] pats [4] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
                              64'hA5A5_5A5A_C3C3_3C3C, 64'h8000_0000_0000_0001};
    for (int i = 0; i < 4; i++) wr(4'(i + 1), pats[i]);
    for (int i = 0; i < 4; i++) expect_read("R2", 4'(i + 1), pats[i], 0, 0);
  endtask

  task automatic t_data_single();
    int bits [4] = '{0, 17, 40, 63};
    for (int i = 0; i < 4; i++) begin
      set_mask(1'b0, 64'(1) << bits[i]);
      wr(4'd5, 64'hDEAD_BEEF_0BAD_F00D);
      expect_read("R3", 4'd5, 64'hDEAD_BEEF_0BAD_F00D, 1, 0);
    end
    set_mask(1'b0, 64'h0);
  endtask

  task automatic t_check_single();
    int bits [3] = '{0, 4, 7};
    for (int i = 0; i < 3; i++) begin
      set_mask(1'b1, 64'(1) << bits[i]);
      wr(4'd6, 64'h1357_9BDF_2468_ACE0);
      expect_read("R4", 4'd6, 64'h1357_9BDF_2468_ACE0, 1, 0);
    end
    set_mask(1'b1, 64'h0);
  endtask

  task automatic t_double();
    logic [63:0] d = 64'hCAFE_F00D_1234_5678;
    set_mask(1'b0, 64'h8000_0000_0000_0001);
    wr(4'd7, d);
    expect_read("R5 data-data", 4'd7, d ^ 64'h8000_0000_0000_0001, 0, 1);
    set_mask(1'b0, 64'h0000_0000_0010_0000);
    set_mask(1'b1, 64'h80);
    wr(4'd8, d);
    expect_read("R5 data-check", 4'd8, d ^ 64'h0000_0000_0010_0000, 0, 1);
    set_mask(1'b0, 64'h0);
    set_mask(1'b1, 64'h03);
    wr(4'd9, d);
    expect_read("R5 check-check", 4'd9, d, 0, 1);
    set_mask(1'b1, 64'h0);
  endtask

  task automatic t_lifetime();
    wr(4'd10, 64'h1111_2222_3333_4444);
    set_mask(1'b0, 64'h0000_0100_0000_0000);
    wr(4'd11, 64'h5555_6666_7777_8888);
    expect_read("R6 older word", 4'd10, 64'h1111_2222_3333_4444, 0, 0);
    expect_read("R6 masked word", 4'd11, 64'h5555_6666_7777_8888, 1, 0);
    set_mask(1'b0, 64'h0);
    wr(4'd12, 64'h9999_AAAA_BBBB_CCCC);
    expect_read("R6 cleared", 4'd12, 64'h9999_AAAA_BBBB_CCCC, 0, 0);
  endtask

  task automatic t_select();
    // check mask must take only the low byte; data mask must stay zero
    set_mask(1'b1, 64'hFFFF_FFFF_FFFF_FF01);
    wr(4'd13, 64'h0F0F_0F0F_0F0F_0F0F);
    expect_read("R7 check only", 4'd13, 64'h0F0F_0F0F_0F0F_0F0F, 1, 0);
    set_mask(1'b0, 64'h0000_0000_0000_0002);
    wr(4'd14, 64'h0F0F_0F0F_0F0F_0F0F);
    expect_read("R7 both kept", 4'd14, 64'h0F0F_0F0F_0F0F_0F0D, 0, 1);
    set_mask(1'b1, 64'h0);
    set_mask(1'b0, 64'h0);
  endtask

  task automatic t_timing();
    logic [63:0] d; logic c, u, v;
    set_mask(1'b0, 64'h4);
    wr(4'd15, 64'h0);
    rd(4'd15, d, c, u, v);
    check("R8 valid on read", 64'(v), 1);
    check("R8 corr on read", 64'(c), 1);
    @(negedge clk);
    check("R8 valid drops", 64'(rd_valid), 0);
    check("R8 corr drops", 64'(err_corr), 0);
    check("R8 data held", rd_data, 64'h0);
    set_mask(1'b0, 64'h0);
  endtask

  task automatic t_collide();
    logic [63:0] d; logic c, u, v;
    wr(4'd3, 64'hAAAA_0000_BBBB_0000);
    wr_en = 1'b1; wr_addr = 4'd3; wr_data = 64'h0000_CCCC_0000_DDDD;
    rd(4'd3, d, c, u, v);
    wr_en = 1'b0;
    check("R9 old word", d, 64'hAAAA_0000_BBBB_0000);
    check("R9 no flag", 64'(c | u), 0);
    expect_read("R9 new word", 4'd3, 64'h0000_CCCC_0000_DDDD, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_data_single();
    t_check_single();
    t_double();
    t_lifetime();
    t_select();
    t_timing();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule